// File: doc/BRIEF.md
# Watchdog Timer with Expiry Event Routing

This block is a watchdog peripheral on a byte-wide register port. Software programs a 24-bit timeout, enables counting, and keeps the timer alive by writing to a restart location. A slow time-base enable (one pulse per 32.768 kHz period, about 30.5 µs) decrements the counter. When the count runs out, the block raises a sticky status flag and emits a one-clock pulse on one destination. A 4-bit selector code picks that destination: one of eleven interrupt request lines, the non-maskable interrupt, or a system reset request.

Register access is a plain single-cycle strobe interface: a write takes effect at the clock edge where `io_wr` is high, and read data is combinational from the address while `io_rd` is high. No data streams through the block, so there is no valid/ready handshake and no back-pressure. All outputs are plain level or pulse pins.

The seven byte registers sit at consecutive offsets from a base address (default 67h). The restart port is at base+0. Control (enable in bit 6) is at base+1. The selector (bits 7:4) is at base+2. The timeout bytes are at base+3, base+4 and base+5, least significant byte first. Status is at base+6: bit 7 is the flag and bit 6 is a restart strobe.

Top module: `wdog_evt_router`

## Requirements
- R1: After reset, every register reads 00h except the restart port at 67h, which always reads FFh; all event outputs are low.
- R2: A write of any value to 67h, or a write to 6Dh with bit 6 set, reloads the counter from the timeout value and re-arms it. A write to 6Dh with bit 6 clear does not restart.
- R3: Bit 6 of 68h enables counting (1 = enabled); while it is 0 the counter holds the timeout value and no expiry occurs. Bits 7 and 5:0 of 68h read 0.
- R4: The timeout is 6Ah (bits 7:0), 6Bh (bits 15:8) and 6Ch (bits 23:16), each read/write. With timeout N ≥ 1 and counting enabled, expiry happens on the N-th tick after a restart. A timeout of 0 expires on the first tick.
- R5: The selector is bits 7:4 of 69h. Codes 1 to 11 drive `irq_o[code-1]` (lines in order IRQ 3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15) high for exactly one clock, in the cycle after the expiring tick; at most one event output is high at a time.
- R6: Code 12 pulses `nmi_o` and code 13 pulses `sysrst_o`, with the same timing as R5.
- R7: Reserved codes 0, 14 and 15 produce no output pulse, but the status flag is still set.
- R8: After expiry the counter stops; further ticks produce no event until a restart.
- R9: Status bit 7 of 6Dh is set on expiry. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R10: Bits 3:0 of 69h and bits 6:0 of 6Dh read 0. Addresses outside 67h to 6Dh read 00h, and `io_rdata` is 00h while `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base enable, one clock high per slow tick |
| io_addr | input | 8 | Register address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| irq_o | output | 11 | One-hot interrupt request pulses |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| sysrst_o | output | 1 | System reset request pulse |

## Verification
The bound assertions check on every cycle that the event outputs are at most one-hot, and that a pulse never lasts two cycles. They also check that a pulse only follows a clock in which a tick was present and counting was enabled, and that the status flag is set whenever a pulse is out. Only the bench scenarios can show that each of the sixteen selector codes reaches the right line, and that a restart from either location postpones expiry. The same holds for write-1-to-clear and the exact tick count, including timeout 0 and a value using the top byte. The bench checks these against a behavioural model on every clock.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  // Register offsets relative to the base address; timeout bytes follow
  // OFS_TO0 in ascending significance, status follows the last byte.
  localparam int unsigned OFS_KICK = 0;
  localparam int unsigned OFS_CTRL = 1;
  localparam int unsigned OFS_SEL  = 2;
  localparam int unsigned OFS_TO0  = 3;

  localparam int unsigned CTRL_EN_BIT   = 6;
  localparam int unsigned STAT_FLAG_BIT = 7;
  localparam int unsigned STAT_KICK_BIT = 6;
  localparam int unsigned SEL_W         = 4;
  localparam int unsigned SEL_LSB       = 4;

  localparam logic [7:0] KICK_READ_VAL = 8'hFF;

  typedef struct packed {
    logic restart;
    logic clr_flag;
  } reg_cmd_t;
endpackage

// File: rtl/wdr_regs.sv
module wdr_regs
  import wdr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h67,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  input  logic              set_flag,
  output logic [7:0]        io_rdata,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  timeout,
  output logic              flag,
  output reg_cmd_t          cmd
);
  localparam int TO_BYTES = CNT_W / 8;
  localparam int OFS_STAT = OFS_TO0 + TO_BYTES;
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [ADDR_W-1:0] off;
  logic              en_q, flag_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  to_q;

  assign off = io_addr - BASE_ADDR;

  assign cmd.restart  = io_wr && ((off == A_KICK) ||
                                  ((off == A_STAT) && io_wdata[STAT_KICK_BIT]));
  assign cmd.clr_flag = io_wr && (off == A_STAT) && io_wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      to_q  <= '0;
    end else if (io_wr) begin
      if (off == A_CTRL) en_q <= io_wdata[CTRL_EN_BIT];
      if (off == A_SEL)  sel_q <= io_wdata[SEL_LSB +: SEL_W];
      for (int b = 0; b < TO_BYTES; b++) begin
        if (off == ADDR_W'(OFS_TO0 + b)) to_q[8*b +: 8] <= io_wdata;
      end
    end
  end

  // A new expiry wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (set_flag)     flag_q <= 1'b1;
    else if (cmd.clr_flag) flag_q <= 1'b0;
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (off == A_KICK) io_rdata = KICK_READ_VAL;
      if (off == A_CTRL) io_rdata[CTRL_EN_BIT] = en_q;
      if (off == A_SEL)  io_rdata[SEL_LSB +: SEL_W] = sel_q;
      if (off == A_STAT) io_rdata[STAT_FLAG_BIT] = flag_q;
      for (int b = 0; b < TO_BYTES; b++) begin
        if (off == ADDR_W'(OFS_TO0 + b)) io_rdata = to_q[8*b +: 8];
      end
    end
  end

  assign en      = en_q;
  assign sel     = sel_q;
  assign timeout = to_q;
  assign flag    = flag_q;
endmodule

// File: rtl/wdr_counter.sv
module wdr_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             last;

  assign last   = (cnt_q <= CNT_W'(1));
  assign expire = en && !restart && tick && armed_q && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (!en || restart) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
    end else if (tick && armed_q) begin
      if (last) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdr_router.sv
module wdr_router
  import wdr_pkg::*;
#(
  parameter int N_IRQ = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SEL_W-1:0] sel,
  output logic [N_IRQ-1:0] irq,
  output logic             nmi,
  output logic             sysrst
);
  localparam logic [SEL_W-1:0] CODE_NMI = SEL_W'(N_IRQ + 1);
  localparam logic [SEL_W-1:0] CODE_RST = SEL_W'(N_IRQ + 2);

  logic [N_IRQ-1:0] irq_d, irq_q;
  logic             nmi_q, rst_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_dec
    assign irq_d[i] = fire && (sel == SEL_W'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      nmi_q <= fire && (sel == CODE_NMI);
      rst_q <= fire && (sel == CODE_RST);
    end
  end

  assign irq    = irq_q;
  assign nmi    = nmi_q;
  assign sysrst = rst_q;
endmodule

// File: rtl/wdog_evt_router.sv
module wdog_evt_router
  import wdr_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h67,
  parameter int CNT_W = 24,
  parameter int N_IRQ = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [7:0]       io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic [N_IRQ-1:0] irq_o,
  output logic             nmi_o,
  output logic             sysrst_o
);
  logic             en_w, flag_w, expire_w;
  logic [SEL_W-1:0] sel_w;
  logic [CNT_W-1:0] timeout_w;
  reg_cmd_t         cmd_w;

  wdr_regs #(.ADDR_W(8), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .set_flag(expire_w), .io_rdata(io_rdata),
    .en(en_w), .sel(sel_w), .timeout(timeout_w), .flag(flag_w), .cmd(cmd_w)
  );

  wdr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_en),
    .restart(cmd_w.restart), .load_val(timeout_w), .expire(expire_w)
  );

  wdr_router #(.N_IRQ(N_IRQ)) route_i (
    .clk(clk), .rst_n(rst_n), .fire(expire_w), .sel(sel_w),
    .irq(irq_o), .nmi(nmi_o), .sysrst(sysrst_o)
  );
endmodule

// File: rtl/wdr_checker.sv
module wdr_checker #(
  parameter int N_IRQ = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             en,
  input logic             flag,
  input logic [N_IRQ-1:0] irq,
  input logic             nmi,
  input logic             sysrst
);
  logic any_evt;
  assign any_evt = (|irq) || nmi || sysrst;

  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, nmi, sysrst})); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> !any_evt); // R8

  AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> $past(tick_en)); // R4

  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> $past(en)); // R3

  AST_FLAG_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> flag); // R9
endmodule

bind wdog_evt_router wdr_checker #(.N_IRQ(N_IRQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .en(en_w), .flag(flag_w),
  .irq(irq_o), .nmi(nmi_o), .sysrst(sysrst_o)
);

// File: tb/wdog_evt_router_tb_top.sv
module wdog_evt_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [10:0] irq_o;
  logic        nmi_o, sysrst_o;

  int n_vec = 0;
  int n_bad = 0;
  int pulses = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // behavioural reference state
  int          m_cnt, m_to, m_sel;
  bit          m_armed, m_en, m_flag, kick, fire;
  logic [12:0] m_evt;

  always #5 clk = ~clk;

  wdog_evt_router dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .irq_o(irq_o), .nmi_o(nmi_o), .sysrst_o(sysrst_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_to = 0; m_sel = 0; m_armed = 1; m_en = 0; m_flag = 0; m_evt = '0;
    end else begin
      kick = io_wr && (io_addr == 8'h67 || (io_addr == 8'h6D && io_wdata[6]));
      fire = m_en && !kick && tick_en && m_armed && (m_cnt <= 1);
      m_evt = '0;
      if (fire) begin
        if (m_sel >= 1 && m_sel <= 11) m_evt[m_sel + 1] = 1'b1;
        else if (m_sel == 12) m_evt[1] = 1'b1;
        else if (m_sel == 13) m_evt[0] = 1'b1;
      end
      if (!m_en || kick) begin m_cnt = m_to; m_armed = 1; end
      else if (tick_en && m_armed) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_armed = 0; end
        else m_cnt = m_cnt - 1;
      end
      if (fire) m_flag = 1;
      else if (io_wr && io_addr == 8'h6D && io_wdata[7]) m_flag = 0;
      if (io_wr) begin
        case (io_addr)
          8'h68: m_en = io_wdata[6];
          8'h69: m_sel = int'(io_wdata[7:4]);
          8'h6A: m_to = (m_to & 32'hFFFF00) | int'(io_wdata);
          8'h6B: m_to = (m_to & 32'hFF00FF) | (int'(io_wdata) << 8);
          8'h6C: m_to = (m_to & 32'h00FFFF) | (int'(io_wdata) << 16);
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison of the event outputs
  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if ({irq_o, nmi_o, sysrst_o} !== m_evt) begin
        n_bad++;
        $display("FAIL %s events: actual %h expected %h", cur_tag,
                 {irq_o, nmi_o, sysrst_o}, m_evt);
      end
      if ((|irq_o) || nmi_o || sysrst_o) pulses++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 chk(tag, int'(io_rdata), exp);
    io_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic wait_one_tick_then_check(input int n, input int exp_pulses, input string tag);
    int p0;
    p0 = pulses;
    ticks(n);
    @(negedge clk);
    chk(tag, pulses - p0, exp_pulses);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cur_tag = "R1";
    rd(8'h67, 8'hFF, "R1 restart port read");
    for (int a = 8'h68; a <= 8'h6D; a++) rd(8'(a), 0, "R1 reset register");
    rd(8'h66, 0, "R10 below base");
    rd(8'h6E, 0, "R10 above range");

    // basic expiry on IRQ line for code 1
    cur_tag = "R4";
    wr(8'h6A, 8'h05); wr(8'h69, 8'h10); wr(8'h68, 8'h40);
    rd(8'h6A, 8'h05, "R4 timeout byte 0");
    wait_one_tick_then_check(4, 0, "R4 no expiry before 5th tick");
    wait_one_tick_then_check(1, 1, "R4 expiry on 5th tick");
    cur_tag = "R8";
    wait_one_tick_then_check(10, 0, "R8 stopped after expiry");
    // R9 write-1-to-clear
    rd(8'h6D, 8'h80, "R9 flag set");
    wr(8'h6D, 8'h00);
    rd(8'h6D, 8'h80, "R9 write 0 keeps flag");
    wr(8'h6D, 8'h80);
    rd(8'h6D, 8'h00, "R9 write 1 clears flag");

    // routing of every selector code
    wr(8'h6A, 8'h03);
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 11) cur_tag = "R5";
      else if (c == 12 || c == 13) cur_tag = "R6";
      else cur_tag = "R7";
      wr(8'h69, 8'(c << 4));
      wr(8'h67, 8'h5A);
      wait_one_tick_then_check(5, (c >= 1 && c <= 13) ? 1 : 0, cur_tag);
      rd(8'h6D, 8'h80, "R7 flag set for every code");
      wr(8'h6D, 8'h80);
    end

    // restart postpones expiry
    cur_tag = "R2";
    wr(8'h69, 8'h20); wr(8'h6A, 8'h06); wr(8'h67, 8'h00);
    wait_one_tick_then_check(4, 0, "R2 before restart");
    wr(8'h67, 8'hC3);
    wait_one_tick_then_check(4, 0, "R2 port restart postpones");
    wr(8'h6D, 8'h40);
    wait_one_tick_then_check(5, 0, "R2 status bit 6 restart");
    wr(8'h6D, 8'h00);
    wait_one_tick_then_check(1, 1, "R2 bit 6 clear does not restart");
    wr(8'h6D, 8'h80);

    // timeout 0
    cur_tag = "R4";
    wr(8'h6A, 8'h00); wr(8'h67, 8'h00);
    wait_one_tick_then_check(1, 1, "R4 timeout 0 first tick");

    // disabled holds the counter
    cur_tag = "R3";
    wr(8'h6A, 8'h02); wr(8'h68, 8'h00);
    wait_one_tick_then_check(20, 0, "R3 disabled no expiry");
    wr(8'h68, 8'hFF);
    rd(8'h68, 8'h40, "R3 reserved control bits");
    wait_one_tick_then_check(2, 1, "R3 enable restarts from timeout");
    wr(8'h69, 8'hFF);
    rd(8'h69, 8'hF0, "R10 selector low bits");
    rd(8'h6D, 8'h80, "R10 status bit 6 reads 0");
    wr(8'h6D, 8'hFF);
    @(negedge clk); io_addr = 8'h67; io_rd = 1'b0;
    #1 chk("R10 rdata idle", int'(io_rdata), 0);

    // top timeout byte
    cur_tag = "R4";
    wr(8'h69, 8'hC0); wr(8'h6A, 8'h00); wr(8'h6B, 8'h00); wr(8'h6C, 8'h01);
    rd(8'h6C, 8'h01, "R4 timeout byte 2");
    rd(8'h6B, 8'h00, "R4 timeout byte 1");
    wr(8'h67, 8'h00);
    wait_one_tick_then_check(65535, 0, "R4 24-bit before end");
    wait_one_tick_then_check(1, 1, "R6 NMI after 65536 ticks");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule